// File: doc/BRIEF.md
# Command-Driven Configuration Port Bridge

This block connects a 32-bit memory-mapped register bus to a word-wide configuration access port. Software loads configuration words into a write FIFO by storing to one register and then issues a command that drains the FIFO onto the port. The drain follows a valid/ready handshake. For readback, software programs a word count and issues a second command. The block then requests that many words from the port and collects them in a read FIFO, which software empties by loading from another register.

Software follows progress by polling three registers: a done flag, the free space in the write FIFO and the fill level of the read FIFO. It can also use a four-source interrupt unit with toggle-on-write status bits. Two control bits clear the FIFOs or return the block to its defaults. Each acts while it is held at 1.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset, status (0x110) reads 0x121 when the port status inputs are idle (done=1, abort_n=1, cfg_err_n=1), write vacancy (0x114) reads WR_DEPTH, read occupancy (0x118) reads 0 and irq is 0.
- R2: A store to 0x100 pushes one word into the write FIFO, and vacancy equals WR_DEPTH minus the words held. A store while the FIFO is full is dropped and does not stall the bus.
- R3: Writing 1 to control bit 0 (0x10C) drains the write FIFO to the port in push order, one word per cycle in which cp_wr_valid and cp_wr_ready are both high. Status bit 0 stays 0 until the FIFO is empty. Issuing the command again during a drain keeps the drain going, so words pushed in the meantime are also sent.
- R4: The size register at 0x108 holds a 12-bit word count. A stored value above 0xFFF is saturated to 0xFFF.
- R5: Writing 1 to control bit 1 transfers `size` words from the port into the read FIFO, one word per cycle in which cp_rd_req and cp_rd_valid are both high. Loads from 0x104 return them in arrival order. A count of 0 starts nothing. A load from an empty read FIFO returns 0 and changes nothing.
- R6: While the read FIFO is full, cp_rd_req stays low. Status bit 0 reads 0 and bit 6 reads 1 until the whole count has arrived.
- R7: Status bits 5, 7 and 8 mirror cp_abort_n, cp_align and cp_cfg_err_n. Bit 6 is the readback-busy flag and bit 0 is the done flag.
- R8: While control bit 2 holds 1, both FIFOs are held empty.
- R9: While control bit 3 holds 1, the interrupt, enable and size registers return to 0, both FIFOs are held empty and the sequencer is idle.
- R10: Interrupt status (0x20) bit 0 sets when the write FIFO reaches half full, bit 1 when the read FIFO reaches half full, bit 2 when the write FIFO becomes empty and bit 3 when the read FIFO becomes full. Each bit sets on the rising edge of its condition, and writing 1 to a bit toggles it.
- R11: irq is 1 exactly when bit 31 of 0x1C is set and some status bit is also set in the enable register (0x28, same bit layout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register store strobe |
| bus_rd | input | 1 | Register load strobe (pops the read FIFO at 0x104) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the cycle of bus_rd |
| cp_wr_valid | output | 1 | Word offered to the port |
| cp_wr_data | output | 32 | Word offered to the port |
| cp_wr_ready | input | 1 | Port accepts the offered word |
| cp_rd_req | output | 1 | Block wants a readback word |
| cp_rd_valid | input | 1 | Port supplies a readback word |
| cp_rd_data | input | 32 | Readback word |
| cp_abort_n | input | 1 | Port abort indicator, active low |
| cp_align | input | 1 | Port data-alignment indicator |
| cp_cfg_err_n | input | 1 | Port configuration error, active low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the cycle-level invariants on every cycle. Port reads are never requested into a full read FIFO, and a store to a full write FIFO leaves it full. The done flag rises only with no words left, and irq never rises without the global enable. A clear or soft reset always takes effect one cycle later. The bench sweeps every fill level of a small write FIFO and every readback count through and past the read FIFO depth, which shows word order, saturation of the size register, stalls and restart of a drain. It also steps the interrupt status through set, toggle and masking sequences, and those effects can only be seen through the register view.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int DW = 32;

  localparam logic [11:0] A_GIE   = 12'h01C;
  localparam logic [11:0] A_ISR   = 12'h020;
  localparam logic [11:0] A_IER   = 12'h028;
  localparam logic [11:0] A_WFIFO = 12'h100;
  localparam logic [11:0] A_RFIFO = 12'h104;
  localparam logic [11:0] A_SIZE  = 12'h108;
  localparam logic [11:0] A_CTRL  = 12'h10C;
  localparam logic [11:0] A_STAT  = 12'h110;
  localparam logic [11:0] A_WVAC  = 12'h114;
  localparam logic [11:0] A_ROCC  = 12'h118;

  localparam int N_IRQ = 4;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WRITE, SEQ_READ} seq_state_e;

  // true once a FIFO holds at least half its depth
  function automatic logic half_or_more(input logic [31:0] cnt, input logic [31:0] depth);
    return (cnt << 1) >= depth;
  endfunction

  function automatic logic [31:0] free_slots(input logic [31:0] cnt, input logic [31:0] depth);
    return depth - cnt;
  endfunction

  function automatic logic [31:0] saturate(input logic [31:0] w, input logic [31:0] lim);
    return (w > lim) ? lim : w;
  endfunction

  function automatic logic [31:0] pack_status(input logic done, input logic abort_n,
                                              input logic rd_busy, input logic align,
                                              input logic cfg_err_n);
    logic [31:0] s;
    s = '0;
    s[0] = done;
    s[5] = abort_n;
    s[6] = rd_busy;
    s[7] = align;
    s[8] = cfg_err_n;
    return s;
  endfunction
endpackage

// File: rtl/cpc_fifo.sv
module cpc_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  assign dout = mem[rp];
endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
  import cpc_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [SIZE_W-1:0] size,
  input  logic              wf_empty,
  input  logic              rf_full,
  input  logic              cp_wr_ready,
  input  logic              cp_rd_valid,
  output logic              cp_wr_valid,
  output logic              cp_rd_req,
  output logic              wf_pop,
  output logic              rf_push,
  output logic              done,
  output logic              rd_busy,
  output logic [SIZE_W-1:0] xfer_left
);
  seq_state_e st;

  assign cp_wr_valid = (st == SEQ_WRITE) && !wf_empty;
  assign wf_pop      = cp_wr_valid && cp_wr_ready;
  assign cp_rd_req   = (st == SEQ_READ) && (xfer_left != '0) && !rf_full;
  assign rf_push     = cp_rd_req && cp_rd_valid;
  assign done        = (st == SEQ_IDLE);
  assign rd_busy     = (st == SEQ_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      xfer_left <= '0;
    end else if (sw_rst) begin
      st        <= SEQ_IDLE;
      xfer_left <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (start_wr) begin
            st <= SEQ_WRITE;
          end else if (start_rd && size != '0) begin
            st        <= SEQ_READ;
            xfer_left <= size;
          end
        end
        SEQ_WRITE: begin
          // a repeated start keeps the drain alive; it ends once empty
          if (wf_empty && !start_wr) st <= SEQ_IDLE;
        end
        SEQ_READ: begin
          if (rf_push) begin
            xfer_left <= xfer_left - 1'b1;
            if (xfer_left == SIZE_W'(1)) st <= SEQ_IDLE;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpc_irq.sv
module cpc_irq #(
  parameter int N = 4,
  parameter logic [N-1:0] COND_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic [N-1:0] cond,
  input  logic         tog_we,
  input  logic [N-1:0] tog_mask,
  input  logic [N-1:0] ier,
  input  logic         gie,
  output logic [N-1:0] isr,
  output logic [N-1:0] cond_rise,
  output logic         irq
);
  logic [N-1:0] prev;
  logic [N-1:0] tog;

  assign cond_rise = cond & ~prev;
  assign tog       = tog_we ? tog_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= COND_INIT;
      isr  <= '0;
    end else if (sw_rst) begin
      prev <= COND_INIT;
      isr  <= '0;
    end else begin
      prev <= cond;
      isr  <= (isr ^ tog) | cond_rise;
    end
  end

  assign irq = gie && |(isr & ier);
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cpc_pkg::*;
#(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int SIZE_W   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [11:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          cp_wr_valid,
  output logic [31:0]   cp_wr_data,
  input  logic          cp_wr_ready,
  output logic          cp_rd_req,
  input  logic          cp_rd_valid,
  input  logic [31:0]   cp_rd_data,
  input  logic          cp_abort_n,
  input  logic          cp_align,
  input  logic          cp_cfg_err_n,
  output logic          irq
);
  localparam int WCW = $clog2(WR_DEPTH + 1);
  localparam int RCW = $clog2(RD_DEPTH + 1);
  localparam logic [31:0] SIZE_MAX = 32'((1 << SIZE_W) - 1);
  // condition vector: {rf_full, wf_empty, rf_half, wf_half}; after reset only wf_empty holds
  localparam logic [N_IRQ-1:0] COND_RESET = 4'b0100;

  // register state
  logic              gie_q;
  logic [N_IRQ-1:0]  ier_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        ctrl_q;   // {soft reset, fifo clear}

  // named internal events
  logic sw_rst, fifo_clr;
  logic wf_push, wf_pop, wf_full, wf_empty;
  logic rf_push, rf_pop, rf_full, rf_empty;
  logic [WCW-1:0] wf_count;
  logic [RCW-1:0] rf_count;
  logic [31:0] wf_dout, rf_dout;
  logic ctrl_we, start_wr, start_rd;
  logic seq_done, rd_busy;
  logic [SIZE_W-1:0] xfer_left;
  logic [N_IRQ-1:0] irq_cond, isr_q, cond_rise;
  logic isr_we;

  assign sw_rst   = ctrl_q[1];
  assign fifo_clr = ctrl_q[0] | ctrl_q[1];
  assign ctrl_we  = bus_wr && (bus_addr == A_CTRL);
  assign start_wr = ctrl_we && bus_wdata[0] && !sw_rst;
  assign start_rd = ctrl_we && bus_wdata[1] && !sw_rst;
  assign wf_push  = bus_wr && (bus_addr == A_WFIFO);
  assign rf_pop   = bus_rd && (bus_addr == A_RFIFO);
  assign isr_we   = bus_wr && (bus_addr == A_ISR);

  // control bits are levels; soft reset does not clear itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[3:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      ier_q  <= '0;
      size_q <= '0;
    end else if (sw_rst) begin
      gie_q  <= 1'b0;
      ier_q  <= '0;
      size_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_GIE)  gie_q  <= bus_wdata[31];
      if (bus_addr == A_IER)  ier_q  <= bus_wdata[N_IRQ-1:0];
      if (bus_addr == A_SIZE) size_q <= SIZE_W'(saturate(bus_wdata, SIZE_MAX));
    end
  end

  cpc_fifo #(.WIDTH(DW), .DEPTH(WR_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(wf_push), .din(bus_wdata), .pop(wf_pop), .dout(wf_dout),
    .count(wf_count), .full(wf_full), .empty(wf_empty)
  );

  cpc_fifo #(.WIDTH(DW), .DEPTH(RD_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(rf_push), .din(cp_rd_data), .pop(rf_pop), .dout(rf_dout),
    .count(rf_count), .full(rf_full), .empty(rf_empty)
  );

  cpc_seq #(.SIZE_W(SIZE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .start_wr(start_wr), .start_rd(start_rd), .size(size_q),
    .wf_empty(wf_empty), .rf_full(rf_full),
    .cp_wr_ready(cp_wr_ready), .cp_rd_valid(cp_rd_valid),
    .cp_wr_valid(cp_wr_valid), .cp_rd_req(cp_rd_req),
    .wf_pop(wf_pop), .rf_push(rf_push),
    .done(seq_done), .rd_busy(rd_busy), .xfer_left(xfer_left)
  );

  assign cp_wr_data = wf_dout;

  assign irq_cond[0] = half_or_more(32'(wf_count), 32'(WR_DEPTH));
  assign irq_cond[1] = half_or_more(32'(rf_count), 32'(RD_DEPTH));
  assign irq_cond[2] = wf_empty;
  assign irq_cond[3] = rf_full;

  cpc_irq #(.N(N_IRQ), .COND_INIT(COND_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .cond(irq_cond), .tog_we(isr_we), .tog_mask(bus_wdata[N_IRQ-1:0]),
    .ier(ier_q), .gie(gie_q), .isr(isr_q), .cond_rise(cond_rise), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_GIE:   bus_rdata = {gie_q, 31'b0};
      A_ISR:   bus_rdata = 32'(isr_q);
      A_IER:   bus_rdata = 32'(ier_q);
      A_RFIFO: bus_rdata = rf_empty ? '0 : rf_dout;
      A_SIZE:  bus_rdata = 32'(size_q);
      A_CTRL:  bus_rdata = {28'b0, ctrl_q, 2'b00};
      A_STAT:  bus_rdata = pack_status(seq_done, cp_abort_n, rd_busy, cp_align, cp_cfg_err_n);
      A_WVAC:  bus_rdata = free_slots(32'(wf_count), 32'(WR_DEPTH));
      A_ROCC:  bus_rdata = 32'(rf_count);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int SIZE_W   = 12,
  localparam int WCW = $clog2(WR_DEPTH + 1),
  localparam int RCW = $clog2(RD_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cp_wr_valid,
  input logic              cp_rd_req,
  input logic              irq,
  input logic              seq_done,
  input logic [SIZE_W-1:0] xfer_left,
  input logic              gie_q,
  input logic [3:0]        ier_q,
  input logic [SIZE_W-1:0] size_q,
  input logic              wf_push,
  input logic              wf_full,
  input logic              wf_pop,
  input logic              fifo_clr,
  input logic              sw_rst,
  input logic [WCW-1:0]    wf_count,
  input logic [RCW-1:0]    rf_count
);
  assert_wr_offer_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_wr_valid |-> !seq_done);

  assert_rd_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rd_req |-> (32'(rf_count) < 32'(RD_DEPTH)));

  assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (xfer_left == '0));

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);

  assert_full_push_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_push && wf_full && !wf_pop && !fifo_clr) |=> (32'(wf_count) == 32'(WR_DEPTH)));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (wf_count == '0 && rf_count == '0));

  assert_soft_reset_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!gie_q && ier_q == '0 && size_q == '0 && seq_done));
endmodule

bind cfg_port_ctrl cpc_checker #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cp_wr_valid(cp_wr_valid), .cp_rd_req(cp_rd_req),
  .irq(irq), .seq_done(seq_done), .xfer_left(xfer_left), .gie_q(gie_q),
  .ier_q(ier_q), .size_q(size_q), .wf_push(wf_push), .wf_full(wf_full),
  .wf_pop(wf_pop), .fifo_clr(fifo_clr), .sw_rst(sw_rst),
  .wf_count(wf_count), .rf_count(rf_count)
);

// File: tb/test_cfg_port_ctrl.sv
`timescale 1ns/1ps
module test_cfg_port_ctrl;
  import cpc_pkg::*;
  localparam int WD = 8;
  localparam int RD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cp_wr_valid, cp_rd_req, irq;
  logic [31:0] cp_wr_data, cp_rd_data;
  logic cp_wr_ready, cp_rd_valid;
  logic cp_abort_n = 1'b1, cp_align = 1'b0, cp_cfg_err_n = 1'b1;

  logic wr_en_b = 1'b0, wr_phase = 1'b0, rd_en_b = 1'b1;
  logic [31:0] rd_src = 32'hA000_0000;
  logic [31:0] cap [256];
  int cap_total = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cfg_port_ctrl #(.WR_DEPTH(WD), .RD_DEPTH(RD), .SIZE_W(12)) i_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_wr_valid(cp_wr_valid),
    .cp_wr_data(cp_wr_data), .cp_wr_ready(cp_wr_ready), .cp_rd_req(cp_rd_req),
    .cp_rd_valid(cp_rd_valid), .cp_rd_data(cp_rd_data), .cp_abort_n(cp_abort_n),
    .cp_align(cp_align), .cp_cfg_err_n(cp_cfg_err_n), .irq(irq)
  );

  // port models
  assign cp_wr_ready = wr_en_b & wr_phase;
  assign cp_rd_valid = rd_en_b;
  assign cp_rd_data  = rd_src;
  always @(posedge clk) begin
    wr_phase <= ~wr_phase;
    if (cp_wr_valid && cp_wr_ready) begin
      cap[cap_total % 256] <= cp_wr_data;
      cap_total <= cap_total + 1;
    end
    if (cp_rd_req && cp_rd_valid) rd_src <= rd_src + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int g = 0; g < 300; g++) begin
      rd(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, base;
    int start, got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_STAT, v);  check("R1 status", v, 32'h121);
    rd(A_WVAC, v);  check("R1 vacancy", v, WD);
    rd(A_ROCC, v);  check("R1 occupancy", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2/R3 sweep every fill level of the write FIFO
    for (int k = 1; k <= WD; k++) begin
      wr_en_b = 1'b0;
      for (int i = 0; i < k; i++) wr(A_WFIFO, 32'h1000 + k * 16 + i);
      rd(A_WVAC, v); check("R2 vacancy", v, WD - k);
      if (k == WD) begin
        wr(A_WFIFO, 32'hDEAD_BEEF);
        rd(A_WVAC, v); check("R2 full push dropped", v, 0);
      end
      start = cap_total;
      wr(A_CTRL, 32'h1);
      idle(4);
      rd(A_STAT, v); check("R3 busy while held", 32'(v[0]), 0);
      wr_en_b = 1'b1;
      wait_done();
      check("R3 word count", cap_total - start, k);
      for (int i = 0; i < k; i++) check("R3 order", cap[(start + i) % 256], 32'h1000 + k * 16 + i);
    end

    // R3 repeated start while draining
    wr_en_b = 1'b0;
    for (int i = 0; i < 3; i++) wr(A_WFIFO, 32'h2000 + i);
    start = cap_total;
    wr(A_CTRL, 32'h1);
    for (int i = 3; i < 5; i++) wr(A_WFIFO, 32'h2000 + i);
    wr(A_CTRL, 32'h1);
    wr_en_b = 1'b1;
    wait_done();
    check("R3 reissue count", cap_total - start, 5);
    for (int i = 0; i < 5; i++) check("R3 reissue order", cap[(start + i) % 256], 32'h2000 + i);

    // R4 size register saturation
    wr(A_SIZE, 32'h0000_0ABC); rd(A_SIZE, v); check("R4 size", v, 32'hABC);
    wr(A_SIZE, 32'h0001_2345); rd(A_SIZE, v); check("R4 saturate", v, 32'hFFF);

    // R5 empty read ignored
    rd(A_RFIFO, v); check("R5 empty read data", v, 0);
    rd(A_ROCC, v);  check("R5 empty read occupancy", v, 0);

    // R5/R6 readback sweep across and past the read FIFO depth
    for (int n = 0; n <= RD + 3; n++) begin
      wr(A_SIZE, n);
      base = rd_src;
      wr(A_CTRL, 32'h2);
      idle(20);
      rd(A_ROCC, v); check("R6 occupancy after stall", v, (n < RD) ? n : RD);
      rd(A_STAT, v);
      check("R6 done flag", 32'(v[0]), (n <= RD) ? 1 : 0);
      check("R7 read busy bit", 32'(v[6]), (n > RD) ? 1 : 0);
      got = 0;
      for (int g = 0; g < 200 && got < n; g++) begin
        rd(A_ROCC, v);
        if (v != 0) begin
          rd(A_RFIFO, v); check("R5 readback data", v, base + got);
          got++;
        end
      end
      wait_done();
      check("R5 readback count", got, n);
      rd(A_ROCC, v); check("R5 drained", v, 0);
    end

    // R7 status mirrors port inputs
    cp_abort_n = 1'b0; cp_align = 1'b1; cp_cfg_err_n = 1'b0;
    rd(A_STAT, v); check("R7 status inputs", v, 32'h081);
    cp_abort_n = 1'b1; cp_align = 1'b0; cp_cfg_err_n = 1'b1;

    // R10/R11 interrupt unit
    wr_en_b = 1'b0;
    rd(A_ISR, v); wr(A_ISR, v);
    rd(A_ISR, v); check("R10 toggle clear", v, 0);
    for (int i = 0; i < WD / 2; i++) wr(A_WFIFO, i);
    rd(A_ISR, v); check("R10 wf half", v, 4'b0001);
    wr_en_b = 1'b1;
    wr(A_CTRL, 32'h1);
    wait_done();
    rd(A_ISR, v); check("R10 wf empty rise", v, 4'b0101);
    wr(A_IER, 32'hF);
    idle(1); check("R11 gie off", 32'(irq), 0);
    wr(A_GIE, 32'h8000_0000);
    idle(1); check("R11 gie on", 32'(irq), 1);
    wr(A_IER, 32'h8);
    idle(1); check("R11 masked", 32'(irq), 0);
    wr(A_SIZE, RD);
    wr(A_CTRL, 32'h2);
    idle(20);
    rd(A_ISR, v); check("R10 rf half and full", v, 4'b1111);
    check("R11 rf full enabled", 32'(irq), 1);
    wr(A_ISR, 32'hF);
    rd(A_ISR, v); check("R10 toggle all", v, 0);
    check("R11 nothing pending", 32'(irq), 0);
    for (int i = 0; i < RD; i++) rd(A_RFIFO, v);
    wr(A_ISR, 32'h2);
    rd(A_ISR, v); check("R10 toggle sets", v, 4'b0010);

    // R8 FIFO clear
    wr_en_b = 1'b0;
    for (int i = 0; i < 3; i++) wr(A_WFIFO, i);
    wr(A_CTRL, 32'h4);
    rd(A_WVAC, v); check("R8 held clear", v, WD);
    wr(A_WFIFO, 32'h55);
    rd(A_WVAC, v); check("R8 push while clear", v, WD);
    wr(A_CTRL, 32'h0);
    wr(A_WFIFO, 32'h55);
    rd(A_WVAC, v); check("R8 after release", v, WD - 1);

    // R9 soft reset
    wr(A_IER, 32'hF); wr(A_SIZE, 32'h7); wr(A_GIE, 32'h8000_0000);
    wr(A_CTRL, 32'h8);
    wr(A_CTRL, 32'h0);
    rd(A_IER, v);  check("R9 ier", v, 0);
    rd(A_GIE, v);  check("R9 gie", v, 0);
    rd(A_SIZE, v); check("R9 size", v, 0);
    rd(A_ISR, v);  check("R9 isr", v, 0);
    rd(A_WVAC, v); check("R9 vacancy", v, WD);
    rd(A_STAT, v); check("R9 status", v, 32'h121);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule